// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and drives two processor interrupt requests from them: a normal request (`irqOut`) and a fast request (`fiqOut`). Each request has its own bank of registers. The two banks share the same source lines. Each bank holds its own enable mask and its own software-interrupt flag. Software reads three views of each bank: the sources that are both active and enabled, the raw sources, and the enable mask.

Enables never change through a read-modify-write. One register offset sets every enable bit written as 1, and a second offset clears every enable bit written as 1. Bits written as 0 leave their enable as it is. Bit 1 of each bank has no external line. The bank's software-interrupt flag drives it.

The bank select is the top address bit, so the fast bank sits 0x100 above the normal bank. Within a bank the byte offsets are:

| Offset | Read | Write |
|---|---|---|
| 0x00 | masked status | no effect |
| 0x04 | raw status | no effect |
| 0x08 | enable mask | set enables |
| 0x0C | 0 | clear enables |
| 0x10 | 0 | software flag |

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every enable bit and both software flags are 0, and `irqOut` and `fiqOut` are low.
- R2: A read at offset 0x04 returns `srcIn & 32'hF8FF0BFC`, with bit 1 replaced by that bank's software flag. The state of `srcIn[1]` never matters.
- R3: A read at offset 0x00 returns the bank's raw status ANDed with its enable mask.
- R4: A write at offset 0x08 sets every enable bit written as 1 and leaves the others unchanged. A read at 0x08 returns the enable mask. Setting a bit that is already set changes nothing.
- R5: A write at offset 0x0C clears every enable bit written as 1 and leaves the others unchanged.
- R6: A write at offset 0x10 loads the bank's software flag from data bit 1, so writing 0 removes the software interrupt. All other data bits are ignored.
- R7: Register address bit 8 selects the bank: 0 selects the normal bank and 1 selects the fast bank. A write to one bank never alters the other bank's enables or software flag.
- R8: Bits 0, 10, 12 to 15 and 24 to 26 read as 0 in every view of both banks, and they cannot be enabled.
- R9: `irqOut` is the OR of the normal bank's masked status. `fiqOut` is the OR of the fast bank's masked status.
- R10: Read data follows the address in the same cycle. A write becomes visible only after the next rising clock edge.
- R11: Reads at unmapped offsets return 0, including unaligned offsets and offsets 0x0C and 0x10. Writes to unmapped offsets, or to offsets 0x00 and 0x04, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| srcIn | input | 32 | Level-sensitive interrupt source lines |
| regAddr | input | 9 | Register byte address; bit 8 selects the bank |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Random set, clear and software-flag writes are aimed at randomly chosen banks while the source lines change at random. After every step, all three readable views of both banks and both outputs are compared with a bench model. This separates true per-bit masking from a bank-wide gate, and it exposes any write that reaches the wrong bank.

Directed cases cover the following:
- writing all ones, which shows that the unused bits cannot be enabled;
- setting a bit that is already set, which exposes a toggle in place of a set;
- software writes with every bit set except bit 1, which show that only bit 1 is honoured;
- writes to read-only and unmapped offsets, which must leave all state intact;
- a same-cycle read during a write, which separates registered writes from write-through.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int SOFT_BIT  = 1;

  // Bit positions that carry no source and hold no enable.
  localparam logic [DATA_W-1:0] UNUSED_BITS = 32'h0700_F401;
  localparam logic [DATA_W-1:0] SOFT_MASK   = DATA_W'(1) << SOFT_BIT;
  localparam logic [DATA_W-1:0] LIVE_MASK   = ~UNUSED_BITS;
  localparam logic [DATA_W-1:0] WIRE_MASK   = LIVE_MASK & ~SOFT_MASK;

  // Byte offsets inside one bank.
  localparam logic [7:0] OFS_MASKED = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_ENABLE = 8'h08;
  localparam logic [7:0] OFS_CLEAR  = 8'h0C;
  localparam logic [7:0] OFS_SOFT   = 8'h10;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_MASKED,
    RD_RAW,
    RD_ENABLE
  } rdKind_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  setStb;
    logic [NUM_BANKS-1:0]  clrStb;
    logic [NUM_BANKS-1:0]  softStb;
    logic [BANK_SEL_W-1:0] rdBank;
    rdKind_t               rdKind;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           stb
);
  localparam int OFS_W = ADDR_W - BANK_SEL_W;

  logic [BANK_SEL_W-1:0] bankIdx;
  logic [OFS_W-1:0]      offset;
  logic                  hitEnable;
  logic                  hitClear;
  logic                  hitSoft;

  assign bankIdx   = regAddr[ADDR_W-1 -: BANK_SEL_W];
  assign offset    = regAddr[OFS_W-1:0];
  assign hitEnable = (offset == OFS_W'(OFS_ENABLE));
  assign hitClear  = (offset == OFS_W'(OFS_CLEAR));
  assign hitSoft   = (offset == OFS_W'(OFS_SOFT));

  // One write strobe of each kind per bank.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankStb
    logic bankHit;
    assign bankHit         = regWrEn && (bankIdx == BANK_SEL_W'(b));
    assign stb.setStb[b]   = bankHit && hitEnable;
    assign stb.clrStb[b]   = bankHit && hitClear;
    assign stb.softStb[b]  = bankHit && hitSoft;
  end

  assign stb.rdBank = bankIdx;

  always_comb begin
    if (offset == OFS_W'(OFS_MASKED))      stb.rdKind = RD_MASKED;
    else if (offset == OFS_W'(OFS_RAW))    stb.rdKind = RD_RAW;
    else if (hitEnable)                    stb.rdKind = RD_ENABLE;
    else                                   stb.rdKind = RD_NONE;
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              setStb,
  input  logic              clrStb,
  input  logic              softStb,
  output logic [DATA_W-1:0] rawStat,
  output logic [DATA_W-1:0] maskedStat,
  output logic [DATA_W-1:0] enableQ,
  output logic              softQ,
  output logic              bankReq
);
  logic [DATA_W-1:0] setBits;
  logic [DATA_W-1:0] clrBits;
  logic [DATA_W-1:0] enableNext;

  assign setBits    = setStb ? wrData : '0;
  assign clrBits    = clrStb ? wrData : '0;
  assign enableNext = ((enableQ | setBits) & ~clrBits) & LIVE_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      softQ   <= 1'b0;
    end else begin
      if (setStb || clrStb) enableQ <= enableNext;
      if (softStb)          softQ   <= wrData[SOFT_BIT];
    end
  end

  assign rawStat    = (srcIn & WIRE_MASK) | (softQ ? SOFT_MASK : '0);
  assign maskedStat = rawStat & enableQ;
  assign bankReq    = |maskedStat;
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [DATA_W-1:0]              srcIn,
  input  logic [DATA_W-1:0]              wrData,
  input  strobe_t                        stb,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_BANKS-1:0]           bankReq,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] enableQ,
  output logic [NUM_BANKS-1:0]           softQ
);
  logic [NUM_BANKS-1:0][DATA_W-1:0] rawStat;
  logic [NUM_BANKS-1:0][DATA_W-1:0] maskedStat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank bank_i (
      .clk        (clk),
      .rstN       (rstN),
      .srcIn      (srcIn),
      .wrData     (wrData),
      .setStb     (stb.setStb[b]),
      .clrStb     (stb.clrStb[b]),
      .softStb    (stb.softStb[b]),
      .rawStat    (rawStat[b]),
      .maskedStat (maskedStat[b]),
      .enableQ    (enableQ[b]),
      .softQ      (softQ[b]),
      .bankReq    (bankReq[b])
    );
  end

  always_comb begin
    rdData = '0;
    if (int'(stb.rdBank) < NUM_BANKS) begin
      unique case (stb.rdKind)
        RD_MASKED: rdData = maskedStat[stb.rdBank];
        RD_RAW:    rdData = rawStat[stb.rdBank];
        RD_ENABLE: rdData = enableQ[stb.rdBank];
        default:   rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       srcIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut,
  output logic              fiqOut
);
  strobe_t                          stb;
  logic [NUM_BANKS-1:0]             bankReq;
  logic [NUM_BANKS-1:0][DATA_W-1:0] enableQ;
  logic [NUM_BANKS-1:0]             softQ;

  intc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  intc_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .wrData  (regWrData),
    .stb     (stb),
    .rdData  (regRdData),
    .bankReq (bankReq),
    .enableQ (enableQ),
    .softQ   (softQ)
  );

  assign irqOut = bankReq[0];
  assign fiqOut = bankReq[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [31:0]                    srcIn,
  input logic [ADDR_W-1:0]              regAddr,
  input logic                           regWrEn,
  input logic [31:0]                    regWrData,
  input logic                           irqOut,
  input logic                           fiqOut,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] enableQ,
  input logic [NUM_BANKS-1:0]           softQ
);
  localparam logic [ADDR_W-1:0] FAST_BIT  = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] A_SET_N   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLR_N   = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_SOFT_N  = ADDR_W'(OFS_SOFT);
  localparam logic [ADDR_W-1:0] A_SET_F   = A_SET_N | FAST_BIT;

  AST_SET_REACHES_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_SET_N) |=>
      ((enableQ[0] & $past(regWrData & LIVE_MASK)) == $past(regWrData & LIVE_MASK))); // R4
  AST_CLEAR_REACHES_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_CLR_N) |=> ((enableQ[0] & $past(regWrData)) == '0)); // R5
  AST_SOFT_FROM_BIT1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_SOFT_N) |=> (softQ[0] == $past(regWrData[1]))); // R6
  AST_FAST_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr[ADDR_W-1]) |=> ($stable(enableQ[1]) && $stable(softQ[1]))); // R7
  AST_NORMAL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_SET_F) |=> ($stable(enableQ[0]) && $stable(softQ[0]))); // R7
  AST_UNUSED_NEVER_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((enableQ[0] & UNUSED_BITS) == '0) && ((enableQ[1] & UNUSED_BITS) == '0)); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enableQ[0] != '0)); // R9
  AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (enableQ[1] != '0)); // R9
  AST_QUIET_WITHOUT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIn & WIRE_MASK) == '0 && softQ == '0) |-> (!irqOut && !fiqOut)); // R9
endmodule

bind dual_bank_intc intc_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .srcIn     (srcIn),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .irqOut    (irqOut),
  .fiqOut    (fiqOut),
  .enableQ   (enableQ),
  .softQ     (softQ)
);

// File: tb/dual_bank_intc_tb_top.sv
`timescale 1ns/1ps
module dual_bank_intc_tb_top;
  localparam logic [31:0] SRC_OK = 32'hF8FF0BFC;
  localparam logic [31:0] EN_OK  = 32'hF8FF0BFE;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] srcIn;
  logic [8:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        irqOut;
  logic        fiqOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  logic [31:0] mEn   [2];
  logic        mSoft [2];

  always #5 clk = ~clk;

  dual_bank_intc dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut)
  );

  function automatic logic [31:0] expRaw(int b);
    return (srcIn & SRC_OK) | (mSoft[b] ? 32'h2 : 32'h0);
  endfunction

  function automatic logic [31:0] expMasked(int b);
    return expRaw(b) & mEn[b];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(logic [8:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic checkAll(string tag);
    logic [31:0] v;
    for (int b = 0; b < 2; b++) begin
      logic [8:0] base;
      base = (b == 1) ? 9'h100 : 9'h000;
      readAt(base | 9'h000, v); check({"R3 masked ", tag}, v, expMasked(b));
      readAt(base | 9'h004, v); check({"R2 raw ", tag}, v, expRaw(b));
      readAt(base | 9'h008, v); check({"R4 enable ", tag}, v, mEn[b]);
    end
    check({"R9 irqOut ", tag}, {31'b0, irqOut}, {31'b0, |expMasked(0)});
    check({"R9 fiqOut ", tag}, {31'b0, fiqOut}, {31'b0, |expMasked(1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rstN = 1'b0; srcIn = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    for (int b = 0; b < 2; b++) begin mEn[b] = '0; mSoft[b] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    srcIn = 32'hFFFF_FFFF;
    @(negedge clk);
    // R1: nothing enabled after reset, so all sources stay hidden
    check("R1 irqOut after reset", {31'b0, irqOut}, 32'h0);
    check("R1 fiqOut after reset", {31'b0, fiqOut}, 32'h0);
    readAt(9'h008, v); check("R1 normal enables after reset", v, 32'h0);
    readAt(9'h108, v); check("R1 fast enables after reset", v, 32'h0);
    // R2 and R8: raw view hides the unused bits and bit 1 without software
    readAt(9'h004, v); check("R2 R8 raw all ones", v, SRC_OK);

    // R8: all-ones set leaves the unused bits disabled
    writeReg(9'h008, 32'hFFFF_FFFF); mEn[0] = EN_OK;
    readAt(9'h008, v); check("R8 enable all ones", v, EN_OK);
    readAt(9'h108, v); check("R7 fast bank untouched", v, 32'h0);
    checkAll("after all-ones set");

    // R4: setting an already set bit changes nothing
    writeReg(9'h00C, 32'hFFFF_FFFF); mEn[0] = '0;
    writeReg(9'h008, 32'h0000_0010); mEn[0] = 32'h10;
    writeReg(9'h008, 32'h0000_0010);
    readAt(9'h008, v); check("R4 repeated set", v, 32'h10);
    // R5: clearing only the written bits
    writeReg(9'h008, 32'h8000_0100); mEn[0] = 32'h8000_0110;
    writeReg(9'h00C, 32'h0000_0100); mEn[0] = 32'h8000_0010;
    readAt(9'h008, v); check("R5 partial clear", v, 32'h8000_0010);

    // R6: only data bit 1 drives the software flag
    srcIn = '0;
    writeReg(9'h008, 32'h2); mEn[0] = mEn[0] | 32'h2;
    writeReg(9'h010, 32'hFFFF_FFFD);
    readAt(9'h004, v); check("R6 soft ignores other bits", v, 32'h0);
    writeReg(9'h010, 32'h2); mSoft[0] = 1'b1;
    readAt(9'h004, v); check("R6 soft set", v, 32'h2);
    check("R6 irqOut from soft", {31'b0, irqOut}, 32'h1);
    check("R7 fiqOut unaffected by normal soft", {31'b0, fiqOut}, 32'h0);
    writeReg(9'h010, 32'h0); mSoft[0] = 1'b0;
    check("R6 irqOut after soft cleared", {31'b0, irqOut}, 32'h0);

    // R2: srcIn bit 1 has no effect
    srcIn = 32'h2;
    readAt(9'h004, v); check("R2 srcIn bit1 ignored", v, 32'h0);

    // R11: unmapped or read-only writes change nothing; unmapped reads 0
    writeReg(9'h000, 32'hFFFF_FFFF);
    writeReg(9'h004, 32'hFFFF_FFFF);
    writeReg(9'h014, 32'hFFFF_FFFF);
    writeReg(9'h009, 32'hFFFF_FFFF);
    writeReg(9'h111, 32'hFFFF_FFFF);
    readAt(9'h008, v); check("R11 enable after stray writes", v, mEn[0]);
    readAt(9'h108, v); check("R11 fast enable after stray writes", v, 32'h0);
    readAt(9'h00C, v); check("R11 clear port reads 0", v, 32'h0);
    readAt(9'h110, v); check("R11 soft port reads 0", v, 32'h0);
    readAt(9'h005, v); check("R11 unaligned reads 0", v, 32'h0);

    // R10: a write is not visible until after the clock edge
    @(negedge clk);
    regAddr = 9'h108; regWrData = 32'h0000_0800; regWrEn = 1'b1;
    #1; check("R10 same cycle read is old", regRdData, 32'h0);
    @(negedge clk);
    regWrEn = 1'b0; mEn[1] = 32'h0000_0800;
    #1; check("R10 read after edge is new", regRdData, 32'h0000_0800);

    // Random mix of set, clear, soft, stray writes and source changes
    for (int i = 0; i < 300; i++) begin
      int op;
      int b;
      logic [31:0] d;
      logic [8:0] base;
      op = int'($urandom % 5);
      b  = int'($urandom % 2);
      base = (b == 1) ? 9'h100 : 9'h000;
      d = $urandom & $urandom;
      case (op)
        0: begin writeReg(base | 9'h008, d); mEn[b] = (mEn[b] | d) & EN_OK; end
        1: begin writeReg(base | 9'h00C, d); mEn[b] = mEn[b] & ~d; end
        2: begin writeReg(base | 9'h010, $urandom); mSoft[b] = regWrData[1]; end
        3: begin
          logic [8:0] stray;
          case ($urandom % 4)
            0: stray = 9'h000;
            1: stray = 9'h004;
            2: stray = 9'h01C;
            default: stray = 9'h00A;
          endcase
          writeReg(base | stray, $urandom);
        end
        default: begin @(negedge clk); srcIn = $urandom; end
      endcase
      if (($urandom % 3) == 0) srcIn = $urandom;
      checkAll("random step");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule